// File: doc/BRIEF.md
# DRAM Command Legality Monitor

This block watches the command bus of a four-bank low-power DDR memory and judges every command against the state of the bank it addresses, the device-wide power state and the minimum command spacing. It samples chip select, the three command strobes, clock enable, the bank address and address bit 10 on each rising clock edge. It keeps its own copy of which banks hold an open row and runs countdown timers for each spacing rule. It never drives the bus.

When a command is illegal or arrives too early, the block raises a one-cycle violation pulse in the cycle after the offending edge, together with a class code. A flagged command does not change the tracked state. The open/idle state of every bank is always visible, so a bus master or a simulation environment can follow the memory without a model of its own.

Clock-enable transitions are decoded as entry to and exit from power-down, self-refresh and deep power-down. Leaving deep power-down, like reset, returns the device to a state in which it must be set up again before normal traffic is allowed.

Top module: `dram_cmd_legality_mon`

## Requirements
- R1: A row-open (ACTIVE: cs low, ras low, cas high, we high) or a single-bank PRECHARGE acts only on the bank numbered by `ba_i`, shown as bit `ba_i` of `bank_open_o`. READ and WRITE are also checked against that bank only.
- R2: With `cs_ni` high, or with the strobes all high, nothing is checked and no state changes. This holds whatever the strobes and address carry.
- R3: PRECHARGE (ras low, cas high, we low) with `a10_i` high closes every open bank. With `a10_i` low it closes only the selected bank. A PRECHARGE to an idle bank is a no-operation.
- R4: AUTO REFRESH (ras low, cas low, we high), MODE SET (all three low), self-refresh entry and deep power-down entry are flagged with code 2 when any bank is open.
- R5: READ (cas low, we high) or WRITE (cas low, we low) to an idle bank, and ACTIVE to an open bank, are flagged with code 0.
- R6: Spacing is counted in cycles as ceil(ns / clock period). The rules are: ACTIVE to READ/WRITE 18 ns; ACTIVE to PRECHARGE 42 ns; ACTIVE to ACTIVE 60 ns on the same bank and 12 ns on any bank; PRECHARGE to ACTIVE, REFRESH or MODE SET 18 ns. A command that comes too early is flagged with code 1.
- R7: After an accepted MODE SET, any command within 2 cycles is flagged with code 1. After an accepted AUTO REFRESH, any command within ceil(72 ns) is flagged with code 1.
- R8: When clock enable falls, the command on that edge selects the mode. Chip select high or a no-operation gives power-down, which is legal with rows open. AUTO REFRESH gives self-refresh. Burst-stop (ras high, cas high, we low) gives deep power-down. Any other encoding is flagged with code 0. While clock enable is low, and on the edge where it rises, no command is checked.
- R9: After reset, and after clock enable rises out of deep power-down, only PRECHARGE, AUTO REFRESH and MODE SET are accepted. Any other command is flagged with code 3. An accepted MODE SET ends this state.
- R10: Checks run in a fixed priority: code 3, then the MODE SET or refresh hold-off, then the command's own state and timing rules. `viol_o` pulses for one cycle after the sampling edge, `viol_code_o` is valid during that pulse, and a flagged command leaves all state unchanged.
- R11: During and right after reset all banks are idle and `viol_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory command clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable as seen on the bus |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank address |
| a10_i | input | 1 | Address bit 10 (all-bank precharge select) |
| viol_o | output | 1 | One-cycle violation pulse |
| viol_code_o | output | 2 | 0 bank state, 1 too early, 2 banks not idle, 3 setup required |
| bank_open_o | output | 4 | Open-row flag per bank |

## Verification
The properties assume that every bus input is a known level at each rising edge and that the bus shares the monitor's clock. They also rely on an open bank implying that setup is complete and that no refresh or mode-set hold-off is running. That follows from the acceptance rules, so the stimulus needs no extra constraint. The bench changes inputs only on falling edges. It mixes directed sequences that hit each rule at its exact boundary cycle with a long random phase. That phase uses every command encoding, chip-select-high cycles with arbitrary strobes, and short clock-enable-low excursions.

// File: rtl/dram_lgl_pkg.sv
package dram_lgl_pkg;
  typedef enum logic [2:0] {
    CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_REF, CMD_MRS, CMD_BST
  } cmd_e;

  typedef enum logic [1:0] {
    VC_BANK_STATE = 2'd0,
    VC_TOO_EARLY  = 2'd1,
    VC_NOT_IDLE   = 2'd2,
    VC_UNINIT     = 2'd3
  } viol_code_e;

  function automatic int unsigned ps_to_cyc(int unsigned ps, int unsigned clk_ps);
    return (ps + clk_ps - 1) / clk_ps;
  endfunction
endpackage

// File: rtl/dram_cycle_timer.sv
module dram_cycle_timer #(
  parameter int unsigned CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic done_o
);
  localparam int unsigned W = (CYC < 2) ? 1 : $clog2(CYC);
  localparam logic [W-1:0] LD = W'((CYC > 0) ? CYC - 1 : 0);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= LD;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/dram_cmd_decode.sv
module dram_cmd_decode
  import dram_lgl_pkg::*;
(
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  output cmd_e cmd_o
);
  always_comb begin
    if (cs_ni) cmd_o = CMD_NOP;
    else begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b011:  cmd_o = CMD_ACT;
        3'b101:  cmd_o = CMD_RD;
        3'b100:  cmd_o = CMD_WR;
        3'b010:  cmd_o = CMD_PRE;
        3'b001:  cmd_o = CMD_REF;
        3'b000:  cmd_o = CMD_MRS;
        3'b110:  cmd_o = CMD_BST;
        default: cmd_o = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/dram_bank_tracker.sv
module dram_bank_tracker #(
  parameter int unsigned T_RCD = 3,
  parameter int unsigned T_RAS = 7,
  parameter int unsigned T_RC  = 10,
  parameter int unsigned T_RP  = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic pre_i,
  output logic open_o,
  output logic rcd_ok_o,
  output logic ras_ok_o,
  output logic rc_ok_o,
  output logic rp_ok_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     open_o <= 1'b0;
    else if (act_i)  open_o <= 1'b1;
    else if (pre_i)  open_o <= 1'b0;
  end

  dram_cycle_timer #(.CYC(T_RCD)) u_rcd (.clk_i, .rst_ni, .load_i(act_i), .done_o(rcd_ok_o));
  dram_cycle_timer #(.CYC(T_RAS)) u_ras (.clk_i, .rst_ni, .load_i(act_i), .done_o(ras_ok_o));
  dram_cycle_timer #(.CYC(T_RC))  u_rc  (.clk_i, .rst_ni, .load_i(act_i), .done_o(rc_ok_o));
  dram_cycle_timer #(.CYC(T_RP))  u_rp  (.clk_i, .rst_ni, .load_i(pre_i), .done_o(rp_ok_o));
endmodule

// File: rtl/dram_cmd_legality_mon.sv
module dram_cmd_legality_mon
  import dram_lgl_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned CLK_PS    = 6000,
  parameter int unsigned RCD_PS    = 18000,
  parameter int unsigned RP_PS     = 18000,
  parameter int unsigned RAS_PS    = 42000,
  parameter int unsigned RC_PS     = 60000,
  parameter int unsigned RRD_PS    = 12000,
  parameter int unsigned RFC_PS    = 72000,
  parameter int unsigned MRD_CYC   = 2,
  localparam int unsigned BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cke_i,
  input  logic                 cs_ni,
  input  logic                 ras_ni,
  input  logic                 cas_ni,
  input  logic                 we_ni,
  input  logic [BA_W-1:0]      ba_i,
  input  logic                 a10_i,
  output logic                 viol_o,
  output logic [1:0]           viol_code_o,
  output logic [NUM_BANKS-1:0] bank_open_o
);
  localparam int unsigned T_RCD = ps_to_cyc(RCD_PS, CLK_PS);
  localparam int unsigned T_RP  = ps_to_cyc(RP_PS,  CLK_PS);
  localparam int unsigned T_RAS = ps_to_cyc(RAS_PS, CLK_PS);
  localparam int unsigned T_RC  = ps_to_cyc(RC_PS,  CLK_PS);
  localparam int unsigned T_RRD = ps_to_cyc(RRD_PS, CLK_PS);
  localparam int unsigned T_RFC = ps_to_cyc(RFC_PS, CLK_PS);

  cmd_e cmd;
  logic cke_q, init_q, deep_q;
  logic fall, rise, run;
  logic [NUM_BANKS-1:0] act_hit, pre_hit, rcd_ok, ras_ok, rc_ok, rp_ok;
  logic rrd_ok, mrd_ok, rfc_ok, mrs_acc, ref_acc, dpd_acc, viol_d;
  viol_code_e code_d;

  dram_cmd_decode u_dec (.cs_ni, .ras_ni, .cas_ni, .we_ni, .cmd_o(cmd));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    dram_bank_tracker #(.T_RCD(T_RCD), .T_RAS(T_RAS), .T_RC(T_RC), .T_RP(T_RP)) u_bank (
      .clk_i, .rst_ni,
      .act_i(act_hit[b]), .pre_i(pre_hit[b]),
      .open_o(bank_open_o[b]), .rcd_ok_o(rcd_ok[b]), .ras_ok_o(ras_ok[b]),
      .rc_ok_o(rc_ok[b]), .rp_ok_o(rp_ok[b])
    );
  end

  dram_cycle_timer #(.CYC(T_RRD))   u_rrd (.clk_i, .rst_ni, .load_i(|act_hit), .done_o(rrd_ok));
  dram_cycle_timer #(.CYC(MRD_CYC)) u_mrd (.clk_i, .rst_ni, .load_i(mrs_acc),  .done_o(mrd_ok));
  dram_cycle_timer #(.CYC(T_RFC))   u_rfc (.clk_i, .rst_ni, .load_i(ref_acc),  .done_o(rfc_ok));

  assign fall = cke_q & ~cke_i;
  assign rise = ~cke_q & cke_i;
  assign run  = cke_q & cke_i;

  always_comb begin
    viol_d  = 1'b0;
    code_d  = VC_BANK_STATE;
    act_hit = '0;
    pre_hit = '0;
    mrs_acc = 1'b0;
    ref_acc = 1'b0;
    dpd_acc = 1'b0;
    if (fall) begin
      // entry mode chosen by the command on the falling-enable edge
      unique case (cmd)
        CMD_NOP: ;
        CMD_REF: if (|bank_open_o) begin viol_d = 1'b1; code_d = VC_NOT_IDLE; end
        CMD_BST: if (|bank_open_o) begin viol_d = 1'b1; code_d = VC_NOT_IDLE; end
                 else dpd_acc = 1'b1;
        default: viol_d = 1'b1;
      endcase
    end else if (run && cmd != CMD_NOP) begin
      if (init_q && !(cmd inside {CMD_PRE, CMD_REF, CMD_MRS})) begin
        viol_d = 1'b1; code_d = VC_UNINIT;
      end else if (!mrd_ok || !rfc_ok) begin
        viol_d = 1'b1; code_d = VC_TOO_EARLY;
      end else begin
        unique case (cmd)
          CMD_ACT:
            if (bank_open_o[ba_i]) viol_d = 1'b1;
            else if (!rc_ok[ba_i] || !rp_ok[ba_i] || !rrd_ok) begin
              viol_d = 1'b1; code_d = VC_TOO_EARLY;
            end else act_hit[ba_i] = 1'b1;
          CMD_RD, CMD_WR:
            if (!bank_open_o[ba_i]) viol_d = 1'b1;
            else if (!rcd_ok[ba_i]) begin viol_d = 1'b1; code_d = VC_TOO_EARLY; end
          CMD_PRE:
            if (a10_i) begin
              if (!(&(ras_ok | ~bank_open_o))) begin viol_d = 1'b1; code_d = VC_TOO_EARLY; end
              else pre_hit = bank_open_o;
            end else if (bank_open_o[ba_i] && !ras_ok[ba_i]) begin
              viol_d = 1'b1; code_d = VC_TOO_EARLY;
            end else pre_hit[ba_i] = bank_open_o[ba_i];
          CMD_REF, CMD_MRS:
            if (|bank_open_o) begin viol_d = 1'b1; code_d = VC_NOT_IDLE; end
            else if (!(&rp_ok)) begin viol_d = 1'b1; code_d = VC_TOO_EARLY; end
            else if (cmd == CMD_REF) ref_acc = 1'b1;
            else mrs_acc = 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_q       <= 1'b1;
      init_q      <= 1'b1;
      deep_q      <= 1'b0;
      viol_o      <= 1'b0;
      viol_code_o <= '0;
    end else begin
      cke_q       <= cke_i;
      viol_o      <= viol_d;
      viol_code_o <= code_d;
      if (rise && deep_q) begin
        deep_q <= 1'b0;
        init_q <= 1'b1;
      end else if (dpd_acc) deep_q <= 1'b1;
      if (mrs_acc) init_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dram_cmd_legality_mon_chk.sv
module dram_cmd_legality_mon_chk #(
  parameter int unsigned NUM_BANKS = 4,
  localparam int unsigned BA_W     = $clog2(NUM_BANKS)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cke_i,
  input logic                 cs_ni,
  input logic                 ras_ni,
  input logic                 cas_ni,
  input logic                 we_ni,
  input logic [BA_W-1:0]      ba_i,
  input logic                 a10_i,
  input logic                 viol_o,
  input logic [1:0]           viol_code_o,
  input logic [NUM_BANKS-1:0] bank_open_o
);
  logic act_now, ref_now;
  assign act_now = !cs_ni && !ras_ni && cas_ni && we_ni;
  assign ref_now = !cs_ni && !ras_ni && !cas_ni && we_ni;

  // R1
  open_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((bank_open_o & ~$past(bank_open_o)) != '0) |-> $past(act_now && cke_i));

  // R2
  cs_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> !viol_o);

  // R4
  ref_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cke_i) && cke_i && ref_now && (|bank_open_o)) |=> (viol_o && viol_code_o == 2'd2));

  // R5
  act_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cke_i) && cke_i && act_now && bank_open_o[ba_i]) |=> (viol_o && viol_code_o == 2'd0));

  // R10
  viol_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> $stable(bank_open_o));

  logic unused_a10;
  assign unused_a10 = a10_i;
endmodule

bind dram_cmd_legality_mon dram_cmd_legality_mon_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cke_i(cke_i), .cs_ni(cs_ni), .ras_ni(ras_ni),
  .cas_ni(cas_ni), .we_ni(we_ni), .ba_i(ba_i), .a10_i(a10_i), .viol_o(viol_o),
  .viol_code_o(viol_code_o), .bank_open_o(bank_open_o)
);

// File: tb/dram_cmd_legality_mon_bench.sv
module dram_cmd_legality_mon_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_PS = 6000;
  localparam int T_RCD = (18000 + CLK_PS - 1) / CLK_PS;
  localparam int T_RP  = (18000 + CLK_PS - 1) / CLK_PS;
  localparam int T_RAS = (42000 + CLK_PS - 1) / CLK_PS;
  localparam int T_RC  = (60000 + CLK_PS - 1) / CLK_PS;
  localparam int T_RRD = (12000 + CLK_PS - 1) / CLK_PS;
  localparam int T_RFC = (72000 + CLK_PS - 1) / CLK_PS;
  localparam int T_MRD = 2;

  localparam bit [2:0] K_ACT = 3'b011, K_RD = 3'b101, K_WR = 3'b100, K_PRE = 3'b010;
  localparam bit [2:0] K_REF = 3'b001, K_MRS = 3'b000, K_BST = 3'b110, K_NOP = 3'b111;

  logic clk = 0, rst_n = 0;
  logic cke = 1, cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1, a10 = 0;
  logic [1:0] ba = 0;
  logic viol;
  logic [1:0] code;
  logic [3:0] opn;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_cmd_legality_mon #(.CLK_PS(CLK_PS)) u_dram_cmd_legality_mon (
    .clk_i(clk), .rst_ni(rst_n), .cke_i(cke), .cs_ni(cs_n), .ras_ni(ras_n),
    .cas_ni(cas_n), .we_ni(we_n), .ba_i(ba), .a10_i(a10),
    .viol_o(viol), .viol_code_o(code), .bank_open_o(opn)
  );

  // reference model state
  bit m_open[4];
  int last_act[4], last_pre[4];
  int last_any_act = -1000, last_mrs = -1000, last_ref = -1000, cyc = 0;
  bit m_cke_q = 1, m_init = 1, m_deep = 0, exp_viol = 0;
  int exp_code = 0;
  string tag = "R11";

  function automatic void flag(int c, string t);
    exp_viol = 1; exp_code = c; tag = t;
  endfunction

  function automatic bit [3:0] open_vec();
    bit [3:0] v;
    for (int i = 0; i < 4; i++) v[i] = m_open[i];
    return v;
  endfunction

  task automatic model_step();
    bit [2:0] k;
    bit any_open;
    int b;
    k = {ras_n, cas_n, we_n};
    b = ba;
    any_open = m_open[0] | m_open[1] | m_open[2] | m_open[3];
    exp_viol = 0; exp_code = 0; tag = "R10";
    if (m_cke_q && !cke) begin
      tag = "R8";
      if (cs_n || k == K_NOP) ;
      else if (k == K_REF) begin if (any_open) flag(2, "R4"); end
      else if (k == K_BST) begin if (any_open) flag(2, "R4"); else m_deep = 1; end
      else flag(0, "R8");
    end else if (!m_cke_q && cke) begin
      tag = "R9";
      if (m_deep) begin m_deep = 0; m_init = 1; end
    end else if (m_cke_q && cke) begin
      if (cs_n || k == K_NOP) tag = "R2";
      else if (m_init && !(k == K_PRE || k == K_REF || k == K_MRS)) flag(3, "R9");
      else if (cyc - last_mrs < T_MRD || cyc - last_ref < T_RFC) flag(1, "R7");
      else if (k == K_ACT) begin
        if (m_open[b]) flag(0, "R5");
        else if (cyc - last_act[b] < T_RC || cyc - last_pre[b] < T_RP || cyc - last_any_act < T_RRD)
          flag(1, "R6");
        else begin m_open[b] = 1; last_act[b] = cyc; last_any_act = cyc; tag = "R1"; end
      end else if (k == K_RD || k == K_WR) begin
        if (!m_open[b]) flag(0, "R5");
        else if (cyc - last_act[b] < T_RCD) flag(1, "R6");
        else tag = "R1";
      end else if (k == K_PRE) begin
        tag = "R3";
        if (a10) begin
          bit early = 0;
          for (int i = 0; i < 4; i++) if (m_open[i] && cyc - last_act[i] < T_RAS) early = 1;
          if (early) flag(1, "R6");
          else for (int i = 0; i < 4; i++) if (m_open[i]) begin m_open[i] = 0; last_pre[i] = cyc; end
        end else if (m_open[b]) begin
          if (cyc - last_act[b] < T_RAS) flag(1, "R6");
          else begin m_open[b] = 0; last_pre[b] = cyc; end
        end
      end else if (k == K_REF || k == K_MRS) begin
        bit early = 0;
        for (int i = 0; i < 4; i++) if (cyc - last_pre[i] < T_RP) early = 1;
        if (any_open) flag(2, "R4");
        else if (early) flag(1, "R6");
        else if (k == K_REF) begin last_ref = cyc; tag = "R7"; end
        else begin last_mrs = cyc; m_init = 0; tag = "R9"; end
      end
    end
    m_cke_q = cke;
    cyc++;
  endtask

  task automatic compare();
    checks++;
    if (viol !== exp_viol) begin
      fails++;
      $display("FAIL %s cyc %0d viol actual %b expected %b", tag, cyc, viol, exp_viol);
    end
    checks++;
    if (opn !== open_vec()) begin
      fails++;
      $display("FAIL %s cyc %0d bank_open actual %b expected %b", tag, cyc, opn, open_vec());
    end
    if (exp_viol) begin
      checks++;
      if (code !== 2'(exp_code)) begin
        fails++;
        $display("FAIL %s cyc %0d code actual %0d expected %0d", tag, cyc, code, exp_code);
      end
    end
  endtask

  task automatic tick(bit c_cke, bit c_cs, bit [2:0] rcw, bit [1:0] b, bit a);
    @(negedge clk);
    compare();
    cke = c_cke; cs_n = c_cs; {ras_n, cas_n, we_n} = rcw; ba = b; a10 = a;
    model_step();
  endtask

  task automatic cmd(bit [2:0] rcw, bit [1:0] b, bit a = 0);
    tick(1, 0, rcw, b, a);
  endtask

  task automatic nop(int n);
    for (int i = 0; i < n; i++) tick(1, 1, K_NOP, 0, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin last_act[i] = -1000; last_pre[i] = -1000; end
    repeat (3) @(negedge clk);
    // R11 reset state
    checks++;
    if (viol !== 1'b0 || opn !== 4'b0) begin
      fails++;
      $display("FAIL R11 reset viol %b open %b expected 0 0000", viol, opn);
    end
    rst_n = 1;
    model_step();

    // R9 setup required after reset
    cmd(K_ACT, 0); nop(1);
    cmd(K_RD, 1); nop(1);
    cmd(K_MRS, 0);
    // R7 mode-set hold-off
    cmd(K_ACT, 1); nop(2);
    // R1 / R6 activate spacing
    cmd(K_ACT, 1);
    cmd(K_ACT, 2);
    cmd(K_ACT, 2);
    cmd(K_RD, 1);
    cmd(K_RD, 2);
    nop(2);
    cmd(K_RD, 1); cmd(K_WR, 2);
    // R5 state errors
    cmd(K_RD, 3); cmd(K_WR, 0); cmd(K_ACT, 1);
    // R4 refresh and mode set with open rows
    cmd(K_REF, 0); cmd(K_MRS, 0);
    // R2 chip select high with arbitrary strobes
    tick(1, 1, K_RD, 3, 1); tick(1, 1, K_REF, 0, 0); tick(1, 1, K_ACT, 1, 0);
    // R6 tRAS boundary on single precharge
    cmd(K_PRE, 1); nop(1);
    cmd(K_PRE, 1);
    cmd(K_PRE, 0);
    // R3 precharge-all, then early reopen
    nop(3);
    cmd(K_PRE, 3, 1);
    cmd(K_ACT, 2); nop(1);
    cmd(K_REF, 0); nop(1); cmd(K_REF, 0);
    // R7 refresh hold-off
    cmd(K_ACT, 0); nop(T_RFC - 3); cmd(K_ACT, 0); nop(1); cmd(K_ACT, 3);
    // R8 active power-down with rows open, illegal entry, self-refresh with rows open
    nop(T_RC);
    tick(0, 1, K_NOP, 0, 0); tick(0, 0, K_RD, 0, 0); tick(1, 1, K_NOP, 0, 0); nop(1);
    tick(0, 0, K_ACT, 1, 0); tick(1, 1, K_NOP, 0, 0);
    tick(0, 0, K_REF, 0, 0); tick(1, 1, K_NOP, 0, 0);
    tick(0, 0, K_BST, 0, 0); tick(1, 1, K_NOP, 0, 0);
    // close, then deep power-down and R9 setup required on exit
    nop(T_RAS); cmd(K_PRE, 0, 1); nop(T_RP);
    tick(0, 0, K_BST, 0, 0); tick(0, 0, K_ACT, 0, 0); tick(1, 1, K_NOP, 0, 0); nop(1);
    cmd(K_ACT, 2); cmd(K_WR, 2); cmd(K_PRE, 2); cmd(K_MRS, 0); nop(2);
    cmd(K_ACT, 2); nop(1);
    // self-refresh with all idle
    nop(T_RAS); cmd(K_PRE, 2); nop(T_RP);
    tick(0, 0, K_REF, 0, 0); tick(0, 1, K_NOP, 0, 0); tick(1, 1, K_NOP, 0, 0); nop(2);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      int r;
      bit [1:0] rb;
      r = $urandom_range(0, 99);
      rb = 2'($urandom_range(0, 3));
      if      (r < 45) nop(1);
      else if (r < 57) cmd(K_ACT, rb);
      else if (r < 63) cmd(K_RD, rb);
      else if (r < 67) cmd(K_WR, rb);
      else if (r < 74) cmd(K_PRE, rb, 1'($urandom_range(0, 1)));
      else if (r < 77) cmd(K_REF, rb);
      else if (r < 79) cmd(K_MRS, rb);
      else if (r < 80) cmd(K_BST, rb);
      else if (r < 85) tick(1, 1, 3'($urandom_range(0, 7)), rb, 1'($urandom_range(0, 1)));
      else if (r < 89) begin
        tick(0, 1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)), rb, 0);
        for (int j = 0; j < $urandom_range(1, 3); j++)
          tick(0, 1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)), rb, 0);
        tick(1, 1, K_NOP, 0, 0);
      end else nop(1);
    end
    nop(2);
    @(negedge clk);
    compare();
    summary();
    $finish;
  end
endmodule